// File: doc/BRIEF.md
# Two-Half Round Sequencer with Word-Order Key Schedule

This block drives a ten-round cipher over a 128-bit block that is held as two 64-bit halves, left and right. It takes a 256-bit key as four 64-bit words, with K1 in the top bits. It never expands or preprocesses that key. Each round it picks one of the four words from a fixed table. The table for decryption differs from the table for encryption in two places. The round function itself sits outside the block and is reached through a set of plug-in ports. The block presents the current halves and the chosen subkey. The external logic returns the two new halves in the same cycle.

Between rounds the block swaps the returned halves. The tenth round keeps them in place. One last step then XORs the same eleventh subkey into both halves. Two helper signals go to the plug-in logic. The first is a 192-bit control vector, built by rotating the upper word of the left half. The second is a fixed interleaving permutation of the right half.

A transfer begins with a one-cycle start pulse while the block is idle. The result comes out with a one-cycle done pulse.

Top module: `lr_round_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, busy and done are 0 and data_out is all zeros.
- R2: A start seen while idle loads left = data_in[127:64] and right = data_in[63:0], and latches key and decrypt. A start seen while busy is ignored, and the running operation finishes with its own operands.
- R3: In rounds 1 to 9 the returned halves are swapped, so rf_right_next becomes the new left and rf_left_next the new right. In round 10 they are kept in place.
- R4: Key word Kn is key[255-64(n-1) -: 64]. With decrypt = 0, rf_subkey in steps 1 to 11 is K1,K2,K3,K4,K2,K1,K3,K4,K3,K2,K1. Steps 1 to 10 are the rounds and step 11 is the final step.
- R5: With decrypt = 1, rf_subkey in steps 1 to 11 is K1,K2,K3,K4,K3,K1,K2,K4,K3,K2,K1.
- R6: In the final step, data_out becomes {left ^ Q11, right ^ Q11}. It keeps that value until the next completion.
- R7: If start is taken at clock edge E, done is high for exactly one cycle after edge E+11, and data_out is valid then.
- R8: rf_ctrl = {V1,Z1,V2,Z2,V3,Z3} with V1 in bits [191:160]. X is rf_left[63:32], with bit 1 = the MSB. Vi is X rotated by 10(i-1) and Zi is X rotated by 10i-5. Rotation by k gives output bit p = input bit ((p-1+k) mod 32)+1.
- R9: rf_perm is rf_right with positions 2j and 2j+32 exchanged for j = 1..16, where position 1 is bit 63. Odd positions stay where they are.
- R10: busy is high from the edge that takes start until the edge that raises done, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | 1 selects the decryption word order |
| data_in | input | 128 | Input block, left half in the top bits |
| key | input | 256 | Key words K1..K4, K1 in the top bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| data_out | output | 128 | Result block |
| rf_left | output | 64 | Current left half to the round function |
| rf_right | output | 64 | Current right half to the round function |
| rf_subkey | output | 64 | Subkey for the current step |
| rf_ctrl | output | 192 | Rotation-extended control vector |
| rf_perm | output | 64 | Interleaved right half |
| rf_left_next | input | 64 | Left half returned by the round function |
| rf_right_next | input | 64 | Right half returned by the round function |

## Verification
The assertions assume three things about the inputs. The plug-in returns its halves combinationally in the same cycle. Start is a plain level that may arrive at any time, including while busy. Reset may cut an operation short. The bench stub is a pure combinational function of the presented halves and subkey, so it meets the first assumption. The bench drives start both from idle and in the middle of a run, and it asserts reset once during a run, so the ignore and abort paths are covered.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  localparam int NUM_ROUNDS = 10;
  localparam int NUM_STEPS  = NUM_ROUNDS + 1;
  localparam int ROUND_W    = $clog2(NUM_STEPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_state_t;

  // word index 0..3 selects K1..K4; step 1..11
  function automatic logic [1:0] key_word_idx(input logic dec, input logic [ROUND_W-1:0] step);
    logic [1:0] w;
    case (step)
      4'd1:  w = 2'd0;
      4'd2:  w = 2'd1;
      4'd3:  w = 2'd2;
      4'd4:  w = 2'd3;
      4'd5:  w = dec ? 2'd2 : 2'd1;
      4'd6:  w = 2'd0;
      4'd7:  w = dec ? 2'd1 : 2'd2;
      4'd8:  w = 2'd3;
      4'd9:  w = 2'd2;
      4'd10: w = 2'd1;
      default: w = 2'd0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/rseq_key_pick.sv
module rseq_key_pick
  import rseq_pkg::*;
#(
  parameter int HALF_W    = 64,
  parameter int KEY_WORDS = 4
) (
  input  logic [KEY_WORDS*HALF_W-1:0] key_q,
  input  logic                        dec_q,
  input  logic [ROUND_W-1:0]          step,
  output logic [HALF_W-1:0]           subkey
);
  logic [HALF_W-1:0] words [KEY_WORDS];

  for (genvar n = 0; n < KEY_WORDS; n++) begin : g_split
    assign words[n] = key_q[(KEY_WORDS-n)*HALF_W-1 -: HALF_W];
  end

  always_comb begin
    subkey = words[key_word_idx(dec_q, step)];
  end
endmodule

// File: rtl/rseq_ctrl_ext.sv
module rseq_ctrl_ext #(
  parameter int WORD_W    = 32,
  parameter int PAIRS     = 3,
  parameter int STEP      = 10,
  parameter int HALF_STEP = 5
) (
  input  logic [WORD_W-1:0]         x,
  output logic [2*PAIRS*WORD_W-1:0] ctrl
);
  function automatic logic [WORD_W-1:0] rot(input logic [WORD_W-1:0] a, input int s);
    int k;
    k = s % WORD_W;
    if (k == 0) return a;
    return (a << k) | (a >> (WORD_W - k));
  endfunction

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    localparam int VTOP = (2*PAIRS - 2*i) * WORD_W - 1;
    localparam int ZTOP = VTOP - WORD_W;
    assign ctrl[VTOP -: WORD_W] = rot(x, STEP*i);
    assign ctrl[ZTOP -: WORD_W] = rot(x, STEP*i + HALF_STEP);
  end
endmodule

// File: rtl/rseq_half_perm.sv
module rseq_half_perm #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0] din,
  output logic [HALF_W-1:0] dout
);
  localparam int QUART = HALF_W / 4;
  localparam int MID   = HALF_W / 2;

  for (genvar p = 1; p <= HALF_W; p++) begin : g_bit
    // position p maps to bit index HALF_W-p
    localparam int PARTNER = (p % 2 == 1) ? p : ((p <= MID) ? p + MID : p - MID);
    assign dout[HALF_W-p] = din[HALF_W-PARTNER];
  end

  if (QUART < 1) begin : g_bad
    $error("HALF_W too small");
  end
endmodule

// File: rtl/lr_round_sequencer.sv
module lr_round_sequencer
  import rseq_pkg::*;
#(
  parameter int HALF_W    = 64,
  parameter int WORD_W    = 32,
  parameter int KEY_WORDS = 4,
  parameter int PAIRS     = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        decrypt,
  input  logic [2*HALF_W-1:0]         data_in,
  input  logic [KEY_WORDS*HALF_W-1:0] key,
  output logic                        busy,
  output logic                        done,
  output logic [2*HALF_W-1:0]         data_out,
  output logic [HALF_W-1:0]           rf_left,
  output logic [HALF_W-1:0]           rf_right,
  output logic [HALF_W-1:0]           rf_subkey,
  output logic [2*PAIRS*WORD_W-1:0]   rf_ctrl,
  output logic [HALF_W-1:0]           rf_perm,
  input  logic [HALF_W-1:0]           rf_left_next,
  input  logic [HALF_W-1:0]           rf_right_next
);
  localparam logic [ROUND_W-1:0] LAST_ROUND = ROUND_W'(NUM_ROUNDS);

  seq_state_t                  st_q;
  logic [ROUND_W-1:0]          rnd_q;
  logic [HALF_W-1:0]           l_q, r_q;
  logic [KEY_WORDS*HALF_W-1:0] key_q;
  logic                        dec_q;
  logic [HALF_W-1:0]           sk;

  rseq_key_pick #(.HALF_W(HALF_W), .KEY_WORDS(KEY_WORDS)) u_key (
    .key_q(key_q), .dec_q(dec_q), .step(rnd_q), .subkey(sk)
  );

  rseq_ctrl_ext #(.WORD_W(WORD_W), .PAIRS(PAIRS)) u_ext (
    .x(l_q[HALF_W-1 -: WORD_W]), .ctrl(rf_ctrl)
  );

  rseq_half_perm #(.HALF_W(HALF_W)) u_perm (
    .din(r_q), .dout(rf_perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      rnd_q    <= '0;
      l_q      <= '0;
      r_q      <= '0;
      key_q    <= '0;
      dec_q    <= 1'b0;
      data_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          l_q   <= data_in[2*HALF_W-1 -: HALF_W];
          r_q   <= data_in[HALF_W-1:0];
          key_q <= key;
          dec_q <= decrypt;
          rnd_q <= ROUND_W'(1);
          st_q  <= S_RUN;
        end
        S_RUN: begin
          rnd_q <= rnd_q + 1'b1;
          if (rnd_q == LAST_ROUND) begin
            l_q  <= rf_left_next;
            r_q  <= rf_right_next;
            st_q <= S_FIN;
          end else begin
            l_q <= rf_right_next;
            r_q <= rf_left_next;
          end
        end
        S_FIN: begin
          data_out <= {l_q ^ sk, r_q ^ sk};
          done     <= 1'b1;
          rnd_q    <= '0;
          st_q     <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign rf_left   = l_q;
  assign rf_right  = r_q;
  assign rf_subkey = sk;
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk
  import rseq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic [127:0]       data_out,
  input logic [ROUND_W-1:0] rnd,
  input logic [191:0]       rf_ctrl,
  input logic [63:0]        rf_right,
  input logic [63:0]        rf_perm
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R10
  busy_before_done_chk: assert property (@(posedge clk) disable iff (rst) done |-> ($past(busy) && !busy));

  // R2
  busy_advances_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || (rnd == $past(rnd) + 1'b1)));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(data_out));

  // R8
  ext_rot_chk: assert property (@(posedge clk) disable iff (rst)
    rf_ctrl[127:96] == {rf_ctrl[181:160], rf_ctrl[191:182]});

  // R9
  perm_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_perm[63] == rf_right[63]) && (rf_perm[62] == rf_right[30]));
endmodule

bind lr_round_sequencer rseq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .data_out(data_out),
  .rnd(rnd_q), .rf_ctrl(rf_ctrl), .rf_right(rf_right), .rf_perm(rf_perm)
);

// File: tb/tb_lr_round_sequencer.sv
module tb_lr_round_sequencer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] data_in = '0;
  logic [255:0] key = '0;
  logic         busy, done;
  logic [127:0] data_out;
  logic [63:0]  rf_left, rf_right, rf_subkey, rf_perm, rf_left_next, rf_right_next;
  logic [191:0] rf_ctrl;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lr_round_sequencer dut (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .data_in(data_in), .key(key),
    .busy(busy), .done(done), .data_out(data_out), .rf_left(rf_left), .rf_right(rf_right),
    .rf_subkey(rf_subkey), .rf_ctrl(rf_ctrl), .rf_perm(rf_perm),
    .rf_left_next(rf_left_next), .rf_right_next(rf_right_next)
  );

  // plug-in stub
  assign rf_left_next  = rf_left ^ {rf_right[55:0], rf_right[63:56]} ^ rf_subkey;
  assign rf_right_next = rf_right + rf_subkey;

  localparam logic [384:0] VECS [4] = '{
    {1'b0, 128'h0123456789abcdef_fedcba9876543210,
     256'h1111111111111111_2222222222222222_3333333333333333_4444444444444444},
    {1'b1, 128'h0123456789abcdef_fedcba9876543210,
     256'h1111111111111111_2222222222222222_3333333333333333_4444444444444444},
    {1'b0, 128'hffffffffffffffff_0000000000000000,
     256'hdeadbeefcafef00d_0badc0de12345678_a5a5a5a55a5a5a5a_0f0f0f0ff0f0f0f0},
    {1'b1, 128'h8000000000000001_7fffffffffffffff,
     256'hdeadbeefcafef00d_0badc0de12345678_a5a5a5a55a5a5a5a_0f0f0f0ff0f0f0f0}
  };
  localparam int ENC_W [11] = '{0,1,2,3,1,0,2,3,2,1,0};
  localparam int DEC_W [11] = '{0,1,2,3,2,0,1,3,2,1,0};

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] kword(input logic [255:0] k, input int idx);
    return k[255-64*idx -: 64];
  endfunction

  function automatic int sched(input bit dec, input int j);
    return dec ? DEC_W[j-1] : ENC_W[j-1];
  endfunction

  function automatic logic [31:0] rot_spec(input logic [31:0] x, input int k);
    logic [31:0] y;
    for (int p = 1; p <= 32; p++) y[32-p] = x[32 - (((p - 1 + k) % 32) + 1)];
    return y;
  endfunction

  function automatic logic [191:0] ext_spec(input logic [31:0] x);
    return {rot_spec(x,0), rot_spec(x,5), rot_spec(x,10), rot_spec(x,15), rot_spec(x,20), rot_spec(x,25)};
  endfunction

  function automatic logic [63:0] perm_spec(input logic [63:0] x);
    logic [63:0] y;
    for (int p = 1; p <= 64; p++) begin
      int q;
      q = (p % 2 == 1) ? p : ((p <= 32) ? p + 32 : p - 32);
      y[64-p] = x[64-q];
    end
    return y;
  endfunction

  function automatic logic [127:0] model(input bit dec, input logic [127:0] d, input logic [255:0] k);
    logic [63:0] l, r, nl, nr, kk;
    l = d[127:64];
    r = d[63:0];
    for (int j = 1; j <= 10; j++) begin
      kk = kword(k, sched(dec, j));
      nl = l ^ {r[55:0], r[63:56]} ^ kk;
      nr = r + kk;
      if (j < 10) begin l = nr; r = nl; end
      else begin l = nl; r = nr; end
    end
    kk = kword(k, sched(dec, 11));
    return {l ^ kk, r ^ kk};
  endfunction

  task automatic run_op(input bit dec, input logic [127:0] d, input logic [255:0] k, input bit poke);
    logic [127:0] exp;
    exp = model(dec, d, k);
    @(negedge clk);
    start = 1'b1; decrypt = dec; data_in = d; key = k;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    chk(rf_left == d[127:64] && rf_right == d[63:0], "R2 halves loaded", {rf_left, rf_right}, d);
    chk(rf_ctrl == ext_spec(d[127:96]), "R8 extension vector", rf_ctrl, ext_spec(d[127:96]));
    chk(rf_perm == perm_spec(d[63:0]), "R9 interleave", rf_perm, perm_spec(d[63:0]));
    for (int m = 1; m <= 11; m++) begin
      if (m > 1) @(negedge clk);
      if (poke && m == 3) begin start = 1'b1; data_in = ~d; key = ~k; decrypt = ~dec; end
      else start = 1'b0;
      chk(rf_subkey == kword(k, sched(dec, m)), dec ? "R5 subkey step" : "R4 subkey step",
          rf_subkey, kword(k, sched(dec, m)));
      chk(done == 1'b0, "R7 no early done", done, 0);
    end
    @(negedge clk);
    chk(done == 1'b1, "R7 done after 11 edges", done, 1);
    chk(busy == 1'b0, "R10 idle at done", busy, 0);
    chk(data_out == exp, poke ? "R2 start ignored while busy" : "R3 R6 result", data_out, exp);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(data_out == exp, "R6 output held", data_out, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && data_out == '0, "R1 during reset", {busy, done, data_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && data_out == '0, "R1 after reset", {busy, done, data_out}, 0);

    for (int v = 0; v < 4; v++)
      run_op(VECS[v][384], VECS[v][383:256], VECS[v][255:0], 1'b0);

    // start pulsed mid-run with other operands
    run_op(1'b0, 128'h00000000000000ff_ff00000000000000,
           256'h0102030405060708_1112131415161718_2122232425262728_3132333435363738, 1'b1);

    // all-zero operands
    run_op(1'b1, '0, '0, 1'b0);

    // reset cuts a run short
    @(negedge clk);
    start = 1'b1; data_in = 128'h5; key = 256'h7;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && done == 0 && data_out == '0, "R1 reset mid-run", {busy, done, data_out}, 0);
    repeat (14) @(negedge clk);
    chk(done == 0, "R10 no completion after abort", done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule